// File: doc/BRIEF.md
# ADC Input Overflow Flag Generator

This block watches the stream of stereo 24-bit samples leaving an ADC, one left/right pair per sample strobe. It flags any pair where either channel's magnitude lies above a near-full-scale threshold, the 24-bit equivalent of -0.3 dBFS. The flag travels through a 16-stage delay line clocked by the sample strobe. It therefore appears on the output in the same sample period as the filtered sample it describes, once the ADC's group delay has elapsed.

After reset is released, detection stays blanked for a settling window of 522 sample strobes. Samples that arrive in that window are never flagged.

The result leaves on a single pin that is shared with a zero-detect flag produced elsewhere. When the overflow enable is 1, the pin carries the delayed overflow flag. When the enable is 0, the pin carries the zero-detect input instead. The overflow path keeps running in the background whatever the enable is set to.

Top module: `adc_clip_flag`

## Requirements
- R1: A sample is over range when the magnitude of its two's-complement value is strictly greater than THRESH (default 8103820, hex 7BA78C), on the left or the right channel. A magnitude equal to THRESH is not over range.
- R2: The most negative code, hex 800000 (magnitude 8388608), counts as over range. The most positive code, hex 7FFFFF, also counts as over range.
- R3: With enable 1, an over-range sample captured on strobe n drives the pin high from the clock edge of strobe n+15 to the clock edge of strobe n+16. Counting the sample's own strobe as the first, this is 16 strobes of latency, and the pin stays high for exactly one sample period per flagged sample.
- R4: The delay line moves only on a clock edge where the sample strobe is 1. On edges without a strobe, the pin value is held.
- R5: The first SETTLE (522) strobes after reset release are never flagged. Only from strobe SETTLE+1 onward can a sample raise the pin.
- R6: With enable 0, the pin equals the zero-detect input in the same cycle, without any register in between.
- R7: While reset is 1 the delay line is cleared, so with enable 1 the pin is low. Each release of reset starts a new settling window.
- R8: Changing the enable does not disturb the overflow path. Flags captured while the enable is 0 still reach the pin at their normal time once the enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStb | input | 1 | One-cycle strobe marking a valid sample pair |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| ovfEn | input | 1 | 1: the pin carries the overflow flag; 0: the pin carries the zero flag |
| zeroFlagIn | input | 1 | Zero-detect flag from outside |
| sharedPin | output | 1 | Shared flag output |

## Verification
The bound checker checks four behaviours on every cycle:
- the pin follows the zero-detect input whenever the enable is 0;
- the pin stays quiet through the settling window, using a strobe counter kept in the checker;
- the pin is held on cycles without a strobe;
- the pin is low on the first cycle after reset.

Some behaviours depend on which sample was presented and when, and only the bench's scenarios can show them:
- the exact 16-strobe latency of each flag;
- the strict threshold boundary on both signs, including the most negative code;
- flags surviving an enable toggle;
- flags being cleared by a reset in the middle of a run.

// File: rtl/adc_clip_pkg.sv
package adc_clip_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic advance;  // move the delay line one sample
    logic armed;    // settling window has elapsed
  } clipCtrl_t;
endpackage

// File: rtl/adc_clip_ctrl.sv
module adc_clip_ctrl
  import adc_clip_pkg::*;
#(
  parameter int SETTLE = 522
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleStb,
  output clipCtrl_t ctrl
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

  logic [CNT_W-1:0] settleCnt;
  logic             armed;

  // Counts sample strobes, not clocks; arms after SETTLE strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
      armed     <= 1'b0;
    end else if (sampleStb && !armed) begin
      settleCnt <= settleCnt + 1'b1;
      if (settleCnt == LAST) armed <= 1'b1;
    end
  end

  always_comb begin
    ctrl.advance = sampleStb;
    ctrl.armed   = armed;
  end
endmodule

// File: rtl/adc_clip_datapath.sv
module adc_clip_datapath
  import adc_clip_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DELAY  = 16,
  parameter logic [DATA_W-1:0] THRESH = DATA_W'(8103820)
) (
  input  logic              clk,
  input  logic              rst,
  input  clipCtrl_t         ctrl,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  input  logic              ovfEn,
  input  logic              zeroFlagIn,
  output logic              sharedPin
);
  localparam int NCH = 2;

  logic [DATA_W-1:0] chanData [NCH];
  logic [NCH-1:0]    chanOver;
  logic              hit;
  logic [DELAY-1:0]  delayLine;

  assign chanData[0] = leftIn;
  assign chanData[1] = rightIn;

  // Magnitude compare per channel; negation of the most negative code
  // yields 2^(DATA_W-1) as an unsigned value, which is correct.
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [DATA_W-1:0] mag;
    always_comb begin
      mag         = chanData[c][DATA_W-1] ? (~chanData[c] + 1'b1) : chanData[c];
      chanOver[c] = (mag > THRESH);
    end
  end

  assign hit = ctrl.armed && (|chanOver);

  // Delay line advanced once per sample
  always_ff @(posedge clk) begin
    if (rst)               delayLine <= '0;
    else if (ctrl.advance) delayLine <= {delayLine[DELAY-2:0], hit};
  end

  assign sharedPin = ovfEn ? delayLine[DELAY-1] : zeroFlagIn;
endmodule

// File: rtl/adc_clip_flag.sv
module adc_clip_flag
  import adc_clip_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DELAY  = 16,
  parameter int SETTLE = 522,
  parameter logic [DATA_W-1:0] THRESH = DATA_W'(8103820)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleStb,
  input  logic [DATA_W-1:0] leftIn,
  input  logic [DATA_W-1:0] rightIn,
  input  logic              ovfEn,
  input  logic              zeroFlagIn,
  output logic              sharedPin
);
  clipCtrl_t ctrl;

  adc_clip_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .ctrl(ctrl)
  );

  adc_clip_datapath #(.DATA_W(DATA_W), .DELAY(DELAY), .THRESH(THRESH)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .leftIn(leftIn), .rightIn(rightIn),
    .ovfEn(ovfEn), .zeroFlagIn(zeroFlagIn), .sharedPin(sharedPin)
  );
endmodule

// File: rtl/adc_clip_flag_chk.sv
module adc_clip_flag_chk #(
  parameter int SETTLE = 522
) (
  input logic clk,
  input logic rst,
  input logic sampleStb,
  input logic ovfEn,
  input logic zeroFlagIn,
  input logic sharedPin
);
  localparam int CW = $clog2(SETTLE + 2);
  localparam logic [CW-1:0] SAT = CW'(SETTLE + 1);

  // Independent strobe counter since reset release, saturating
  logic [CW-1:0] stbSeen;
  always_ff @(posedge clk) begin
    if (rst) stbSeen <= '0;
    else if (sampleStb && stbSeen != SAT) stbSeen <= stbSeen + 1'b1;
  end

  AST_SELECT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ovfEn |-> (sharedPin == zeroFlagIn)); // R6

  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ovfEn && stbSeen <= CW'(SETTLE)) |-> !sharedPin); // R5

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (ovfEn && $past(ovfEn) && !$past(sampleStb) && !$past(rst)) |-> $stable(sharedPin)); // R4

  AST_RESET_LOW: assert property (@(posedge clk)
    ($fell(rst) && ovfEn) |-> !sharedPin); // R7
endmodule

bind adc_clip_flag adc_clip_flag_chk #(.SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst(rst), .sampleStb(sampleStb), .ovfEn(ovfEn),
  .zeroFlagIn(zeroFlagIn), .sharedPin(sharedPin)
);

// File: tb/adc_clip_flag_test.sv
`timescale 1ns/1ps
module adc_clip_flag_test;
  localparam int SETTLE = 522;
  localparam int LAT    = 16;
  localparam logic [23:0] THR = 24'h7BA78C;
  localparam int NVEC = 12;
  // {left, right, expected over-range}
  localparam logic [48:0] VECS [NVEC] = '{
    {24'h000000, 24'h000000, 1'b0},
    {THR,        24'h000000, 1'b0},  // R1 tie
    {THR + 24'd1, 24'h000000, 1'b1}, // R1
    {24'h000000, THR + 24'd1, 1'b1}, // R1 right
    {24'h845874, 24'h000000, 1'b0},  // R1 negative tie
    {24'h845873, 24'h000000, 1'b1},  // R1 negative over
    {24'h800000, 24'h000000, 1'b1},  // R2
    {24'h7FFFFF, 24'h000000, 1'b1},  // R2
    {24'h400000, 24'hC00000, 1'b0},
    {24'h000000, 24'h800000, 1'b1},  // R2 right
    {24'h7FFFFF, 24'h800000, 1'b1},
    {24'h123456, 24'hFEDCBA, 1'b0}
  };

  logic clk = 0, rst = 1, sampleStb = 0, ovfEn = 1, zeroFlagIn = 0;
  logic [23:0] leftIn = '0, rightIn = '0;
  logic sharedPin;
  int nChk = 0, nBad = 0, stbNum = 0;
  logic hist [0:2047];

  always #4 clk = ~clk;

  adc_clip_flag uut (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .leftIn(leftIn),
    .rightIn(rightIn), .ovfEn(ovfEn), .zeroFlagIn(zeroFlagIn),
    .sharedPin(sharedPin)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: sharedPin=%0b expected=%0b (strobe %0d)", tag, act, exp, stbNum);
    end
  endtask

  function automatic logic modelPin();
    logic f;
    f = (stbNum >= LAT) ? hist[stbNum - LAT + 1] : 1'b0;
    return ovfEn ? f : zeroFlagIn;
  endfunction

  // One strobe; checks right after the edge and again before the next strobe
  task automatic sendAndCheck(input string tag, input logic [23:0] l,
                              input logic [23:0] r, input logic over);
    @(negedge clk);
    leftIn = l; rightIn = r; sampleStb = 1;
    @(negedge clk);
    sampleStb = 0;
    stbNum++;
    hist[stbNum] = over && (stbNum > SETTLE);
    check(tag, sharedPin, modelPin());
    repeat (3) @(negedge clk);
    check({tag, " R4 hold"}, sharedPin, modelPin());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) hist[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 reset low", sharedPin, 1'b0);
    ovfEn = 0; zeroFlagIn = 1;
    #1 check("R6 zero select in reset", sharedPin, 1'b1);
    ovfEn = 1; zeroFlagIn = 0;
    @(negedge clk) rst = 0;

    // R5: settling window, every sample full scale but must be ignored
    for (int i = 0; i < SETTLE; i++)
      sendAndCheck("R5 settle", 24'h800000, 24'h7FFFFF, 1'b1);

    // R1 R2 R3: table walked twice, then flushed
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < NVEC; i++)
        sendAndCheck("R1/R2/R3 vector", VECS[i][48:25], VECS[i][24:1], VECS[i][0]);
    for (int i = 0; i < LAT; i++)
      sendAndCheck("R3 flush", 24'h0, 24'h0, 1'b0);

    // R3: single isolated hit, exact latency and width
    sendAndCheck("R3 single", 24'h800000, 24'h0, 1'b1);
    for (int i = 0; i < LAT + 2; i++)
      sendAndCheck("R3 latency", 24'h0, 24'h0, 1'b0);

    // R6 R8: disable while hits travel, toggle zero flag, re-enable
    sendAndCheck("R8 load", 24'h7FFFFF, 24'h0, 1'b1);
    sendAndCheck("R8 load", 24'h7FFFFF, 24'h0, 1'b1);
    ovfEn = 0;
    for (int i = 0; i < 8; i++) begin
      zeroFlagIn = i[0];
      #1 check("R6 comb follow", sharedPin, zeroFlagIn);
      sendAndCheck("R6/R8 disabled", (i == 3) ? 24'h800000 : 24'h0, 24'h0, i == 3);
    end
    ovfEn = 1; zeroFlagIn = 0;
    for (int i = 0; i < LAT; i++)
      sendAndCheck("R8 re-enabled", 24'h0, 24'h0, 1'b0);

    // R7: reset with hits in flight, then a fresh settling window
    sendAndCheck("R7 preload", 24'h800000, 24'h0, 1'b1);
    sendAndCheck("R7 preload", 24'h800000, 24'h0, 1'b1);
    @(negedge clk) rst = 1;
    @(negedge clk) check("R7 mid-run reset", sharedPin, 1'b0);
    rst = 0;
    stbNum = 0;
    for (int i = 0; i < 2048; i++) hist[i] = 1'b0;
    for (int i = 0; i < 24; i++)
      sendAndCheck("R7/R5 re-settle", 24'h800000, 24'h800000, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule